// File: doc/BRIEF.md
# Interrupt Eligibility Bank

This block keeps the per-line state for a bank of interrupt lines and computes, every cycle, which lines may be signalled to a processor. The state per line has several parts: a pending latch, a trigger-mode bit (edge or level), an enable bit, an active bit, a group bit and a group-modifier bit. Each part is stored as a bitmap. Software-style logic upstream changes each bitmap through a pair of write-one-to-set and write-one-to-clear masks. The raw interrupt lines are synchronised inside the block. A rising edge on a line that is in edge mode sets its pending latch. A line in level mode is a candidate for as long as its synchronised input stays high.

A candidate line becomes eligible under two conditions. First, it must be enabled and not active. Second, its group class must be open. The group class is set by the group bit and the modifier bit taken together, and each class has its own global enable. A security-disable control forces every modifier bit to zero. The bank works on the whole vector at once with bitwise logic. The eligibility vector is registered, and a priority selector or routing stage downstream uses it.

Top module: `irq_elig_bank`

## Requirements
- R1: While reset is asserted and after its release, every bitmap is zero and `elig_o` is all zeros. Zero means level mode, group bit 0, modifier 0, disabled, not active and not pending.
- R2: A line whose pending latch is set, and which is enabled, not active and in an open group, shows 1 in `elig_o` two cycles after the edge at which `pend_set_i` was sampled.
- R3: A line in level mode (trigger bit 0) is a candidate while its input is high. The input passes two synchroniser flops and then the output register, so `elig_o` follows the input three edges after the input is sampled.
- R4: A line in edge mode (trigger bit 1) sets its pending latch on a rising edge of its synchronised input. The latch then stays set after the input falls, until `pend_clr_i` clears it.
- R5: A line is eligible only if its enable bit is 1 and its active bit is 0. A line that is active and pending gives 0.
- R6: When `g1ns_en_i` is 1, lines with group bit 1 pass the group gate.
- R7: When `g1s_en_i` is 1, lines with group bit 0 and modifier bit 1 pass the group gate.
- R8: When `g0_en_i` is 1, lines with group bit 0 and modifier bit 0 pass the group gate. With all three group enables at 0, `elig_o` is all zeros.
- R9: When `sec_dis_i` is 1, every modifier bit is read as 0. A line with group bit 0 and modifier bit 1 then passes only through `g0_en_i`, and never through `g1s_en_i`.
- R10: Each bitmap is updated as (old OR set) AND NOT clear. When set and clear hit the same bit in the same cycle, the bit ends at 0. For the pending latch this holds even when a rising edge arrives in that cycle.
- R11: A change on any control input (`g0_en_i`, `g1s_en_i`, `g1ns_en_i`, `sec_dis_i`) shows on `elig_o` after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Raw interrupt inputs |
| pend_set_i | input | NUM_LINES | Pending latch set mask |
| pend_clr_i | input | NUM_LINES | Pending latch clear mask |
| trig_set_i | input | NUM_LINES | Trigger mode set mask (1 = edge) |
| trig_clr_i | input | NUM_LINES | Trigger mode clear mask |
| grp_set_i | input | NUM_LINES | Group bit set mask |
| grp_clr_i | input | NUM_LINES | Group bit clear mask |
| mod_set_i | input | NUM_LINES | Group modifier set mask |
| mod_clr_i | input | NUM_LINES | Group modifier clear mask |
| en_set_i | input | NUM_LINES | Enable set mask |
| en_clr_i | input | NUM_LINES | Enable clear mask |
| act_set_i | input | NUM_LINES | Active set mask |
| act_clr_i | input | NUM_LINES | Active clear mask |
| g0_en_i | input | 1 | Opens group 0 (group 0, modifier 0) |
| g1s_en_i | input | 1 | Opens secure group 1 (group 0, modifier 1) |
| g1ns_en_i | input | 1 | Opens non-secure group 1 (group 1) |
| sec_dis_i | input | 1 | Reads all modifier bits as 0 |
| elig_o | output | NUM_LINES | Registered eligibility vector |

## Verification
The bench builds the bank with its defaults: 32 lines and two synchroniser stages. A cycle model in the bench therefore predicts the fixed latencies of three edges from a raw line and two edges from a set mask. With 32 lines, each of the three group classes can sit on its own line in one vector, next to level-mode and edge-mode lines. Every control combination can then be applied to all of them together. Random sparse masks create frequent same-cycle set/clear collisions and edges that coincide with clears. Random control updates sweep the security-disable override across all group classes.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

  typedef struct packed {
    logic g0_en;
    logic g1s_en;
    logic g1ns_en;
    logic sec_dis;
  } grp_ctl_t;

endpackage

// File: rtl/irq_w1sc_reg.sv
module irq_w1sc_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] bits_d;
  logic             upd_en;

  // clear takes priority over set
  always_comb begin
    upd_en = |(set_i | clr_i);
    bits_d = (bits_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
    end else if (upd_en) begin
      bits_q <= bits_d;
    end
  end

  assign q_o = bits_q;

endmodule

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = raw_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= stage_q[LAST];
    end
  end

  assign level_o = stage_q[LAST];
  assign rise_o  = stage_q[LAST] & ~prev_q;

endmodule

// File: rtl/irq_elig_gate.sv
module irq_elig_gate
  import irq_elig_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] edge_mode_i,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] grp_i,
  input  logic [WIDTH-1:0] mod_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] act_i,
  input  grp_ctl_t         ctl_i,
  output logic [WIDTH-1:0] elig_o
);

  logic [WIDTH-1:0] cand;
  logic [WIDTH-1:0] mod_eff;
  logic [WIDTH-1:0] open_mask;
  logic [WIDTH-1:0] elig_d;
  logic [WIDTH-1:0] elig_q;

  always_comb begin
    cand      = (pend_i | (~edge_mode_i & level_i)) & en_i & ~act_i;
    mod_eff   = ctl_i.sec_dis ? '0 : mod_i;
    open_mask = '0;
    if (ctl_i.g1ns_en) open_mask = open_mask | grp_i;
    if (ctl_i.g1s_en)  open_mask = open_mask | (~grp_i & mod_eff);
    if (ctl_i.g0_en)   open_mask = open_mask | (~grp_i & ~mod_eff);
    elig_d    = cand & open_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_q <= '0;
    end else begin
      elig_q <= elig_d;
    end
  end

  assign elig_o = elig_q;

endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
  import irq_elig_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [NUM_LINES-1:0] pend_set_i,
  input  logic [NUM_LINES-1:0] pend_clr_i,
  input  logic [NUM_LINES-1:0] trig_set_i,
  input  logic [NUM_LINES-1:0] trig_clr_i,
  input  logic [NUM_LINES-1:0] grp_set_i,
  input  logic [NUM_LINES-1:0] grp_clr_i,
  input  logic [NUM_LINES-1:0] mod_set_i,
  input  logic [NUM_LINES-1:0] mod_clr_i,
  input  logic [NUM_LINES-1:0] en_set_i,
  input  logic [NUM_LINES-1:0] en_clr_i,
  input  logic [NUM_LINES-1:0] act_set_i,
  input  logic [NUM_LINES-1:0] act_clr_i,
  input  logic                 g0_en_i,
  input  logic                 g1s_en_i,
  input  logic                 g1ns_en_i,
  input  logic                 sec_dis_i,
  output logic [NUM_LINES-1:0] elig_o
);

  logic [NUM_LINES-1:0] level_s;
  logic [NUM_LINES-1:0] rise_s;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] trig_q;
  logic [NUM_LINES-1:0] grp_q;
  logic [NUM_LINES-1:0] mod_q;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] act_q;
  logic [NUM_LINES-1:0] pend_set_all;
  grp_ctl_t             ctl;

  assign ctl = '{g0_en: g0_en_i, g1s_en: g1s_en_i, g1ns_en: g1ns_en_i, sec_dis: sec_dis_i};

  // edge-mode lines latch a synchronised rising edge
  assign pend_set_all = pend_set_i | (rise_s & trig_q);

  irq_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .raw_i(irq_lines_i), .level_o(level_s), .rise_o(rise_s)
  );

  irq_w1sc_reg #(.WIDTH(NUM_LINES)) u_pend (
    .clk_i, .rst_ni, .set_i(pend_set_all), .clr_i(pend_clr_i), .q_o(pend_q)
  );
  irq_w1sc_reg #(.WIDTH(NUM_LINES)) u_trig (
    .clk_i, .rst_ni, .set_i(trig_set_i), .clr_i(trig_clr_i), .q_o(trig_q)
  );
  irq_w1sc_reg #(.WIDTH(NUM_LINES)) u_grp (
    .clk_i, .rst_ni, .set_i(grp_set_i), .clr_i(grp_clr_i), .q_o(grp_q)
  );
  irq_w1sc_reg #(.WIDTH(NUM_LINES)) u_mod (
    .clk_i, .rst_ni, .set_i(mod_set_i), .clr_i(mod_clr_i), .q_o(mod_q)
  );
  irq_w1sc_reg #(.WIDTH(NUM_LINES)) u_en (
    .clk_i, .rst_ni, .set_i(en_set_i), .clr_i(en_clr_i), .q_o(en_q)
  );
  irq_w1sc_reg #(.WIDTH(NUM_LINES)) u_act (
    .clk_i, .rst_ni, .set_i(act_set_i), .clr_i(act_clr_i), .q_o(act_q)
  );

  irq_elig_gate #(.WIDTH(NUM_LINES)) u_gate (
    .clk_i, .rst_ni,
    .pend_i(pend_q), .edge_mode_i(trig_q), .level_i(level_s),
    .grp_i(grp_q), .mod_i(mod_q), .en_i(en_q), .act_i(act_q),
    .ctl_i(ctl), .elig_o(elig_o)
  );

endmodule

// File: rtl/irq_elig_chk.sv
module irq_elig_chk #(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] elig_o,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] act_q,
  input logic [NUM_LINES-1:0] pend_set_i,
  input logic [NUM_LINES-1:0] pend_clr_i,
  input logic                 g0_en_i,
  input logic                 g1s_en_i,
  input logic                 g1ns_en_i,
  input logic                 sec_dis_i
);

  assert_active_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_o & $past(act_q)) == '0);

  assert_enable_needed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_o & ~$past(en_q)) == '0);

  assert_all_groups_closed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!g0_en_i && !g1s_en_i && !g1ns_en_i) |-> elig_o == '0);

  assert_secdis_no_g1s_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sec_dis_i && g1s_en_i && !g0_en_i && !g1ns_en_i) |-> elig_o == '0);

  assert_clear_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(pend_set_i & pend_clr_i) |=> (pend_q & $past(pend_set_i & pend_clr_i)) == '0);

  assert_pend_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~pend_q & $past(pend_q & ~pend_clr_i)) == '0);

endmodule

bind irq_elig_bank irq_elig_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .elig_o(elig_o), .pend_q(pend_q),
  .en_q(en_q), .act_q(act_q), .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i),
  .g0_en_i(g0_en_i), .g1s_en_i(g1s_en_i), .g1ns_en_i(g1ns_en_i), .sec_dis_i(sec_dis_i)
);

// File: tb/tb_irq_elig_bank.sv
`timescale 1ns/1ps
module tb_irq_elig_bank;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] lines;
  logic [N-1:0] pset, pclr, tset, tclr, gset, gclr, mset, mclr, eset, eclr, aset, aclr;
  logic         g0, g1s, g1ns, sdis;
  logic [N-1:0] elig;

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [N-1:0] m_s1, m_s2, m_s3, m_pend, m_trig, m_grp, m_mod, m_en, m_act, m_elig;

  always #2.5 clk = ~clk;

  irq_elig_bank #(.NUM_LINES(N), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .pend_set_i(pset), .pend_clr_i(pclr), .trig_set_i(tset), .trig_clr_i(tclr),
    .grp_set_i(gset), .grp_clr_i(gclr), .mod_set_i(mset), .mod_clr_i(mclr),
    .en_set_i(eset), .en_clr_i(eclr), .act_set_i(aset), .act_clr_i(aclr),
    .g0_en_i(g0), .g1s_en_i(g1s), .g1ns_en_i(g1ns), .sec_dis_i(sdis),
    .elig_o(elig)
  );

  function automatic logic [N-1:0] exp_elig(
    input logic [N-1:0] pend, trig, lvl, grp, md, en, act,
    input logic c0, c1s, c1ns, sd);
    logic [N-1:0] cand, me, open;
    cand = (pend | (~trig & lvl)) & en & ~act;
    me   = sd ? '0 : md;
    open = '0;
    if (c1ns) open |= grp;
    if (c1s)  open |= ~grp & me;
    if (c0)   open |= ~grp & ~me;
    return cand & open;
  endfunction

  function automatic logic [N-1:0] w1sc(input logic [N-1:0] q, s, c);
    return (q | s) & ~c;
  endfunction

  task automatic model_reset();
    {m_s1, m_s2, m_s3, m_pend, m_trig, m_grp, m_mod, m_en, m_act, m_elig} = '0;
  endtask

  task automatic model_edge();
    logic [N-1:0] rise, nelig;
    rise  = m_s2 & ~m_s3 & m_trig;
    nelig = exp_elig(m_pend, m_trig, m_s2, m_grp, m_mod, m_en, m_act, g0, g1s, g1ns, sdis);
    m_pend = w1sc(m_pend, pset | rise, pclr);
    m_trig = w1sc(m_trig, tset, tclr);
    m_grp  = w1sc(m_grp, gset, gclr);
    m_mod  = w1sc(m_mod, mset, mclr);
    m_en   = w1sc(m_en, eset, eclr);
    m_act  = w1sc(m_act, aset, aclr);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = lines;
    m_elig = nelig;
  endtask

  task automatic check(input string tag);
    checks++;
    if (elig !== m_elig) begin
      errors++;
      $display("FAIL %s: elig_o actual=%h expected=%h at %0t", tag, elig, m_elig, $time);
    end
  endtask

  task automatic zero_masks();
    {pset, pclr, tset, tclr, gset, gclr, mset, mclr, eset, eclr, aset, aclr} = '0;
  endtask

  // one clock: model follows the edge, compare at the falling edge, then clear masks
  task automatic step(input string tag, input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag);
      zero_masks();
    end
  endtask

  task automatic set_ctl(input logic c0, c1s, c1ns, sd);
    g0 = c0; g1s = c1s; g1ns = c1ns; sdis = sd;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    lines = '0;
    zero_masks();
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    model_reset();
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check("R1 reset");
    end
    rst_n = 1'b1;
    step("R1 after release", 2);

    // R2: pending latch with group 0 open
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    eset = 32'h0000_0008;
    pset = 32'h0000_0008;
    step("R2 pending set", 1);
    step("R2 pending visible", 3);
    pclr = 32'h0000_0008;
    step("R2 pending cleared", 3);

    // R3: level-triggered line follows input
    eset = 32'h0000_0020;
    step("R3 enable", 1);
    lines[5] = 1'b1;
    step("R3 level high", 4);
    lines[5] = 1'b0;
    step("R3 level low", 4);

    // R4: edge-triggered line latches rising edge
    tset = 32'h0000_0080;
    eset = 32'h0000_0080;
    step("R4 config", 1);
    lines[7] = 1'b1;
    step("R4 edge", 2);
    lines[7] = 1'b0;
    step("R4 latched", 5);
    pclr = 32'h0000_0080;
    step("R4 cleared", 3);

    // R5: active and enable gating
    pset = 32'h0000_0008;
    step("R5 repend", 2);
    aset = 32'h0000_0008;
    step("R5 active blocks", 3);
    aclr = 32'h0000_0008;
    step("R5 active cleared", 2);
    eclr = 32'h0000_0008;
    step("R5 disabled", 3);

    // R6, R7, R8: one line per group class
    gset = 32'h0000_0400;            // line 10: group 1
    mset = 32'h0000_0800;            // line 11: group 0 modifier 1
    eset = 32'h0000_1C00;            // line 12: group 0 modifier 0
    pset = 32'h0000_1C00;
    step("R6 config", 2);
    set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
    step("R6 g1ns only", 2);
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    step("R7 g1s only", 2);
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    step("R8 g0 only", 2);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    step("R8 all closed", 2);

    // R9: security disable collapses modifier
    set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
    step("R9 g1s with sec_dis", 2);
    set_ctl(1'b1, 1'b0, 1'b0, 1'b1);
    step("R9 g0 with sec_dis", 2);

    // R11: control toggles each cycle
    for (int i = 0; i < 8; i++) begin
      set_ctl(i[0], i[1], i[2], i[0] ^ i[1]);
      step("R11 ctl toggle", 1);
    end

    // R10: set and clear collide, also with a rising edge
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    pset = 32'h0000_1000;
    pclr = 32'h0000_1000;
    step("R10 collide", 3);
    tset = 32'h0001_0000;
    eset = 32'h0001_0000;
    step("R10 config", 1);
    lines[16] = 1'b1;
    step("R10 sync", 2);
    pclr = 32'h0001_0000;            // edge detected in this cycle
    step("R10 edge vs clear", 3);
    lines = '0;
    step("R10 settle", 3);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      pset = $urandom & $urandom & $urandom;
      pclr = $urandom & $urandom & $urandom;
      tset = $urandom & $urandom & $urandom & $urandom;
      tclr = $urandom & $urandom & $urandom & $urandom;
      gset = $urandom & $urandom & $urandom & $urandom;
      gclr = $urandom & $urandom & $urandom & $urandom;
      mset = $urandom & $urandom & $urandom & $urandom;
      mclr = $urandom & $urandom & $urandom & $urandom;
      eset = $urandom & $urandom & $urandom;
      eclr = $urandom & $urandom & $urandom & $urandom;
      aset = $urandom & $urandom & $urandom & $urandom;
      aclr = $urandom & $urandom & $urandom;
      lines = lines ^ ($urandom & $urandom);
      if (($urandom % 16) == 0) begin
        set_ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      step("R2-mix random", 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule